// File: doc/BRIEF.md
# Lane-Partitioned 64-bit Adder

This block is a purely combinational 64-bit adder whose carry chain can be broken at byte-aligned lane boundaries. A single pass through the adder produces eight 8-bit sums, four 16-bit sums, two 32-bit sums or one 64-bit sum. This is the form packed multimedia data needs. The lanes are independent because the carry is stopped at each lane edge. No separate narrow adders are used.

A 2-bit mode input picks the lane width. A subtract select makes every lane compute a minus b. The carry leaving each lane is reported on an 8-bit vector, one bit per byte of the datapath. The enclosing pipeline decides which results and flags it uses.

Top module: `simd_part_adder`

## Requirements
- R1: With mode_i = 2'b00 the block produces eight independent 8-bit results. Byte k of sum_o depends only on byte k of a_i and b_i.
- R2: With mode_i = 2'b01 the block produces four independent 16-bit results on bits [16k+15:16k].
- R3: With mode_i = 2'b10 the block produces two independent 32-bit results on bits [32k+31:32k].
- R4: With mode_i = 2'b11 the block produces one 64-bit result, and the carry runs through all 64 bits.
- R5: With sub_i = 1 every lane computes a minus b. This is done as a + ~b + 1, with the +1 injected at the lowest bit of every lane.
- R6: When adding, the carry out of a lane appears on lane_cout_o at the bit whose index is the lane's top byte: (lane start bit + lane width)/8 - 1.
- R7: When subtracting, the reported lane carry is 1 exactly when the lane's a is greater than or equal to its b as unsigned values (no borrow).
- R8: Every lane_cout_o bit that is not the top byte of a lane reads 0.
- R9: Results wrap modulo 2 to the lane width, with no saturation.
- R10: No carry crosses a lane boundary. An all-ones lane plus one becomes zero and leaves the next lane untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand (subtrahend when subtracting) |
| mode_i | input | 2 | Lane width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sub_i | input | 1 | 1 = subtract b from a in every lane |
| sum_o | output | 64 | Packed lane results |
| lane_cout_o | output | 8 | Per-lane carry out, indexed by the lane's top byte |

## Verification
Each lane width is driven with a sweep that takes every value of a low byte and pairs it with a spread of second operands. The bytes are skewed differently in every lane, so a carry that leaks into the next lane changes that lane's value and is caught. Both add and subtract are swept. The subtract sweep separates a +1 injected only at bit 0 from a +1 injected at every lane base, and it checks the borrow sense of the carry flag. Directed vectors cover the points where the carry meets a boundary: all-ones plus one, zero minus one, and equal operands. These show whether the chain is cut in the right places and whether the flag lands on the right bit.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  localparam int unsigned DATA_W  = 64;
  localparam int unsigned SEG_W   = 8;
  localparam int unsigned NUM_SEG = DATA_W / SEG_W;
  localparam int unsigned MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    LANE_8  = 2'b00,
    LANE_16 = 2'b01,
    LANE_32 = 2'b10,
    LANE_64 = 2'b11
  } lane_mode_e;

endpackage

// File: rtl/simd_add_slice.sv
module simd_add_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] b_x;
  logic [W:0]   c;

  assign b_x  = b_i ^ {W{inv_b_i}};
  assign c[0] = cin_i;

  // bitwise ripple; the slice is one segment of the partitioned chain
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_x[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_x[i]) | (c[i] & (a_i[i] ^ b_x[i]));
  end

  assign cout_o = c[W];

  always_comb begin
    assert_slice_sum_R9: assert ({cout_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, cin_i}))
      else $error("slice sum mismatch");
  end

endmodule

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl #(
  parameter int unsigned NUM_SEG = 8,
  parameter int unsigned MODE_W  = 2
) (
  input  logic [MODE_W-1:0]  mode_i,
  output logic [NUM_SEG-1:0] seg_first_o,
  output logic [NUM_SEG-1:0] seg_last_o
);

  localparam int unsigned MAX_LOG = $clog2(NUM_SEG);

  logic [MAX_LOG:0] span_mask;

  always_comb begin
    if (int'(mode_i) >= MAX_LOG) span_mask = (MAX_LOG+1)'(NUM_SEG - 1);
    else                         span_mask = (MAX_LOG+1)'((1 << mode_i) - 1);
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    assign seg_first_o[k] = ((MAX_LOG+1)'(k) & span_mask) == '0;
    assign seg_last_o[k]  = ((MAX_LOG+1)'(k + 1) & span_mask) == '0;
  end

  always_comb begin
    assert_first_base_R10: assert (seg_first_o[0])
      else $error("segment 0 must start a lane");
    assert_last_top_R8: assert (seg_last_o[NUM_SEG-1])
      else $error("top segment must end a lane");
    assert_lane_pairs_R6: assert ($countones(seg_first_o) == $countones(seg_last_o))
      else $error("lane starts and ends disagree");
  end

endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
  import simd_add_pkg::*;
(
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               sub_i,
  output logic [DATA_W-1:0]  sum_o,
  output logic [NUM_SEG-1:0] lane_cout_o
);

  logic [NUM_SEG-1:0] seg_first;
  logic [NUM_SEG-1:0] seg_last;
  logic [NUM_SEG-1:0] seg_cin;
  logic [NUM_SEG-1:0] seg_cout;

  simd_lane_ctrl #(
    .NUM_SEG (NUM_SEG),
    .MODE_W  (MODE_W)
  ) u_ctrl (
    .mode_i      (mode_i),
    .seg_first_o (seg_first),
    .seg_last_o  (seg_last)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    // a lane base takes the subtract +1, any other segment takes the chain
    if (k == 0) begin : g_base
      assign seg_cin[k] = sub_i;
    end else begin : g_link
      assign seg_cin[k] = seg_first[k] ? sub_i : seg_cout[k-1];
    end

    simd_add_slice #(.W(SEG_W)) u_slice (
      .a_i     (a_i[k*SEG_W +: SEG_W]),
      .b_i     (b_i[k*SEG_W +: SEG_W]),
      .inv_b_i (sub_i),
      .cin_i   (seg_cin[k]),
      .sum_o   (sum_o[k*SEG_W +: SEG_W]),
      .cout_o  (seg_cout[k])
    );

    assign lane_cout_o[k] = seg_last[k] & seg_cout[k];
  end

  always_comb begin
    if (mode_i == LANE_64 && !sub_i)
      assert_full_add_R4: assert ({lane_cout_o[NUM_SEG-1], sum_o} ==
                                  ({1'b0, a_i} + {1'b0, b_i}))
        else $error("64-bit add mismatch");
    if (mode_i == LANE_64 && sub_i)
      assert_no_borrow_R7: assert (lane_cout_o[NUM_SEG-1] == (a_i >= b_i))
        else $error("64-bit borrow flag mismatch");
    if (mode_i == LANE_8 && !sub_i)
      assert_byte_lane_R1: assert (sum_o[SEG_W-1:0] ==
                                   SEG_W'(a_i[SEG_W-1:0] + b_i[SEG_W-1:0]))
        else $error("byte lane 0 mismatch");
    if (mode_i == LANE_16 && sub_i)
      assert_half_sub_R5: assert (sum_o[15:0] == 16'(a_i[15:0] - b_i[15:0]))
        else $error("16-bit lane 0 difference mismatch");
  end

endmodule

// File: tb/simd_part_adder_tb.sv
`timescale 1ns/1ps
module simd_part_adder_tb;

  logic        clk = 1'b0;
  logic [63:0] a, b, sum;
  logic [1:0]  mode;
  logic        sub;
  logic [7:0]  cout;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  simd_part_adder u_dut (
    .a_i(a), .b_i(b), .mode_i(mode), .sub_i(sub),
    .sum_o(sum), .lane_cout_o(cout)
  );

  // reference: per-lane arithmetic on 65-bit values
  task automatic ref_model(input logic [63:0] x, input logic [63:0] y,
                           input logic [1:0] m, input logic s,
                           output logic [63:0] es, output logic [7:0] ec,
                           output logic [7:0] tops);
    int w = 8 << m;
    logic [64:0] msk = (65'd1 << w) - 65'd1;
    es = '0; ec = '0; tops = '0;
    for (int l = 0; l < 64 / w; l++) begin
      int off = l * w;
      logic [64:0] av = ({1'b0, x} >> off) & msk;
      logic [64:0] bv = ({1'b0, y} >> off) & msk;
      logic [64:0] full;
      if (s) bv = (~bv) & msk;
      full = av + bv + {64'd0, s};
      es = es | 64'((full & msk) << off);
      ec[(off + w) / 8 - 1]   = full[w];
      tops[(off + w) / 8 - 1] = 1'b1;
    end
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y,
                       input logic [1:0] m, input logic s);
    logic [63:0] es;
    logic [7:0] ec, tops;
    string rt;
    @(negedge clk);
    a = x; b = y; mode = m; sub = s;
    #1;
    ref_model(x, y, m, s, es, ec, tops);
    case (m)
      2'b00: rt = s ? "R1/R5/R9" : "R1/R9";
      2'b01: rt = s ? "R2/R5/R9" : "R2/R9";
      2'b10: rt = s ? "R3/R5/R9" : "R3/R9";
      default: rt = s ? "R4/R5/R9" : "R4/R9";
    endcase
    checks++;
    if (sum !== es) begin
      fails++;
      $display("FAIL %s sum a=%h b=%h mode=%0d sub=%0b actual=%h expected=%h",
               rt, x, y, m, s, sum, es);
    end
    checks++;
    if ((cout & tops) !== ec) begin
      fails++;
      $display("FAIL %s lane carry mode=%0d actual=%h expected=%h",
               s ? "R7" : "R6", m, cout & tops, ec);
    end
    checks++;
    if ((cout & ~tops) !== 8'h00) begin
      fails++;
      $display("FAIL R8 unused carry bits mode=%0d actual=%h expected=00",
               m, cout & ~tops);
    end
  endtask

  task automatic expect_direct(input string tag, input logic [63:0] es,
                               input logic [7:0] ec);
    checks++;
    if (sum !== es || cout !== ec) begin
      fails++;
      $display("FAIL %s actual=%h/%h expected=%h/%h", tag, sum, cout, es, ec);
    end
  endtask

  function automatic logic [63:0] spread(input logic [7:0] v, input int k0);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v + 8'(k0 * k) ^ 8'(k * 29);
    return r;
  endfunction

  initial begin
    #(10ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    a = '0; b = '0; mode = 2'b00; sub = 1'b0;
    // idle state: zero operands give zero results and flags
    #1;
    expect_direct("R1 zero operands", 64'd0, 8'h00);

    // R10: carries stop at each boundary
    apply(64'h0000_0000_0000_00FF, 64'd1, 2'b00, 1'b0);
    expect_direct("R10 byte wrap", 64'h0, 8'h01);
    apply(64'h0000_0000_0000_FFFF, 64'd1, 2'b01, 1'b0);
    expect_direct("R10 half wrap", 64'h0, 8'h02);
    apply(64'h0000_0000_FFFF_FFFF, 64'd1, 2'b10, 1'b0);
    expect_direct("R10 word wrap", 64'h0, 8'h08);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'b11, 1'b0);
    expect_direct("R4 R9 full wrap", 64'h0, 8'h80);
    // R7: zero minus one borrows in every lane; equal operands do not
    apply(64'd0, 64'h0101_0101_0101_0101, 2'b00, 1'b1);
    expect_direct("R5 R7 zero minus one", 64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    apply(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 2'b01, 1'b1);
    expect_direct("R7 equal operands", 64'h0, 8'hAA);

    // sweeps: every low byte against a spread of second operands, both ops
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 256; i++)
          for (int j = 0; j < 256; j += 17)
            apply(spread(8'(i), 53), spread(8'(j), 77), 2'(m), 1'(s));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule